// File: doc/BRIEF.md
# Single-precision floating-point subtract core

This unit forms x minus y for two 32-bit IEEE-754 single-precision operands and registers the outcome in one pipeline stage. Each operand is first sorted into one of six classes: signalling NaN, quiet NaN, infinity, zero, denormal or normal. Pairs that involve a NaN, an infinity or a zero are settled at once, and the unit emits a finished 32-bit word together with an invalid-operation flag.

Every other pair goes through the magnitude datapath. The sign of y is inverted and the pair is treated as an addition. Denormal operands are renormalized first. The two significands gain three low bits for guard, round and sticky. The operand with the smaller exponent is shifted right, and every bit shifted out is folded into the sticky bit. The magnitudes are then added or subtracted. A carry out of the sum is folded back into the result. A difference is renormalized with a leading-zero count and one barrel shift. The unit hands sign, exponent and the 27-bit significand to a separate rounder. A flag on the output tells that rounder whether the word is already final.

A 2-bit rounding-mode input sets the sign of an exactly zero result.

Top module: `fsub_core`

## Requirements
- R1: The outputs are registered with a latency of one clock. `out_valid` in a cycle equals `in_valid` of the previous cycle. While `rst_n` is low, `out_valid` is 0.
- R2: When x is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the result is x with bit 22 set, whatever y is. The result is final and `out_invalid` is 1. Otherwise, when y is a signalling NaN, the result is y with bit 22 set, also final and invalid.
- R3: When neither operand is a signalling NaN and x is a quiet NaN (fraction bit 22 set), the result is x unchanged. When x is not a NaN and y is a quiet NaN, the result is y unchanged. Neither case raises invalid.
- R4: For infinity minus infinity with equal signs, the result is 0x7FC00000 with `out_invalid` set. With opposite signs, the result is x.
- R5: For finite x minus infinite y, the result is an infinity (exponent all ones, fraction 0) whose sign is the inverse of y's sign. For infinite x minus finite y, the result is x.
- R6: For zero minus zero with different signs, the result is x. With equal signs, the result is a zero that is negative only when `rmode` is 2'b11 (toward minus infinity). The other encodings are 00 nearest-even, 01 toward zero and 10 toward plus infinity.
- R7: For a nonzero finite x minus a zero, the result is x. For a zero minus a nonzero finite y, the result is y with bit 31 inverted. Denormals count as nonzero finite here.
- R8: For two nonzero finite operands whose difference is not exactly zero, `out_final` is 0 and `out_word` is 0. Bit 26 of `out_mant` is 1. The value is (-1)^out_sign x out_mant x 2^(out_exp-26), where `out_exp` is the signed unbiased exponent. A denormal input counts with its true value. Bits 2..0 of `out_mant` are guard, round and sticky.
- R9: During alignment, the smaller-exponent significand, extended by 3 zero bits, is shifted right by the exponent difference. Any 1 shifted out sets bit 0 of the shifted value. A difference of 27 or more leaves just the sticky bit.
- R10: When the aligned magnitudes cancel exactly, the result is final: +0 (0x00000000), or -0 (0x80000000) when `rmode` is 2'b11. `out_invalid` is 0.
- R11: When the effective signs match and the 28-bit sum carries out, the sum is shifted right by one bit. The bit dropped is ORed into bit 0, and the exponent becomes the larger exponent plus one.
- R12: `out_invalid` is 1 only for the cases in R2 and R4, and it is never 1 when `out_final` is 0. For results that are not final, the sign is that of the larger-magnitude aligned operand, with y's sign inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| x_in | input | 32 | Minuend, IEEE-754 single |
| y_in | input | 32 | Subtrahend, IEEE-754 single |
| rmode | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| out_valid | output | 1 | Result present |
| out_final | output | 1 | 1: `out_word` is the finished result; 0: rounder fields are used |
| out_invalid | output | 1 | Invalid-operation exception |
| out_word | output | 32 | Finished result when `out_final` is 1, else 0 |
| out_sign | output | 1 | Sign for the rounder |
| out_exp | output | 10 | Signed unbiased exponent for the rounder |
| out_mant | output | 27 | Normalized significand with guard, round, sticky |

## Verification
The bench builds the unit with its default widths: an 8-bit exponent and a 23-bit fraction. These are the widths at which the special-class words and the hand-computed significands can be written as plain hex. Both widths are small enough that a bench model can shift one bit at a time across the full exponent span, from the smallest denormal up to the largest normal. This brings the sticky fold on very long alignments, exact cancellation and the extreme left renormalization of denormal differences within reach of directed and random operand pairs.

// File: rtl/fsub_pkg.sv
package fsub_pkg;
  parameter int FP_EXP_W  = 8;
  parameter int FP_FRAC_W = 23;

  typedef enum logic [2:0] {
    FC_ZERO,
    FC_DNORM,
    FC_NORM,
    FC_INF,
    FC_QNAN,
    FC_SNAN
  } fp_class_e;
endpackage

// File: rtl/fsub_classify.sv
module fsub_classify
  import fsub_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MW    = FRAC_W + 1,
  localparam int EW    = EXP_W + 2
) (
  input  logic [W-1:0]          op,
  output fp_class_e             cls,
  output logic                  sign,
  output logic signed [EW-1:0]  exp_u,
  output logic [MW-1:0]         mant
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  function automatic int lead_zeros(input logic [MW-1:0] v);
    int n;
    n = MW;
    for (int i = 0; i < MW; i++) begin
      if (v[i]) n = MW - 1 - i;
    end
    return n;
  endfunction

  logic [EXP_W-1:0]  e_f;
  logic [FRAC_W-1:0] f_f;
  int                lz;

  always_comb begin
    e_f   = op[W-2:FRAC_W];
    f_f   = op[FRAC_W-1:0];
    sign  = op[W-1];
    lz    = lead_zeros({1'b0, f_f});
    mant  = {1'b1, f_f};
    exp_u = EW'(int'(e_f) - BIAS);
    if (&e_f) begin
      if (f_f == '0)          cls = FC_INF;
      else if (f_f[FRAC_W-1]) cls = FC_QNAN;
      else                    cls = FC_SNAN;
    end else if (e_f == '0) begin
      cls   = (f_f == '0) ? FC_ZERO : FC_DNORM;
      mant  = MW'({1'b0, f_f} << lz);
      exp_u = EW'(1 - BIAS - lz);
    end else begin
      cls = FC_NORM;
    end
  end
endmodule

// File: rtl/fsub_special.sv
module fsub_special
  import fsub_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  fp_class_e    cx,
  input  fp_class_e    cy,
  input  logic [1:0]   rmode,
  output logic         hit,
  output logic [W-1:0] word,
  output logic         invalid
);
  localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);

  function automatic logic [W-1:0] inf_word(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [W-1:0] dflt_nan();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  endfunction

  logic x_nan, y_nan, x_inf, y_inf, x_zero, y_zero;

  always_comb begin
    x_nan   = (cx == FC_QNAN) || (cx == FC_SNAN);
    y_nan   = (cy == FC_QNAN) || (cy == FC_SNAN);
    x_inf   = (cx == FC_INF);
    y_inf   = (cy == FC_INF);
    x_zero  = (cx == FC_ZERO);
    y_zero  = (cy == FC_ZERO);
    hit     = 1'b1;
    invalid = 1'b0;
    word    = x;
    if (cx == FC_SNAN) begin
      word = x | QBIT; invalid = 1'b1;
    end else if (cy == FC_SNAN) begin
      word = y | QBIT; invalid = 1'b1;
    end else if (x_nan) begin
      word = x;
    end else if (y_nan) begin
      word = y;
    end else if (x_inf && y_inf) begin
      if (x[W-1] == y[W-1]) begin
        word = dflt_nan(); invalid = 1'b1;
      end
    end else if (y_inf) begin
      word = inf_word(~y[W-1]);
    end else if (x_inf) begin
      word = x;
    end else if (x_zero && y_zero) begin
      if (x[W-1] == y[W-1]) word = {rmode == 2'b11, {(W-1){1'b0}}};
    end else if (y_zero) begin
      word = x;
    end else if (x_zero) begin
      word = {~y[W-1], y[W-2:0]};
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/fsub_arith.sv
module fsub_arith
  import fsub_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W,
  localparam int MW    = FRAC_W + 1,
  localparam int XW    = MW + 3,
  localparam int EW    = EXP_W + 2
) (
  input  logic                 xs,
  input  logic                 ys,
  input  logic signed [EW-1:0] xe,
  input  logic signed [EW-1:0] ye,
  input  logic [MW-1:0]        xm,
  input  logic [MW-1:0]        ym,
  output logic                 cancel,
  output logic                 carry,
  output logic                 r_sign,
  output logic signed [EW-1:0] r_exp,
  output logic [XW-1:0]        r_mant
);
  function automatic logic [XW-1:0] sticky_shift(input logic [XW-1:0] m, input int d);
    logic [XW-1:0] mask;
    if (d == 0) return m;
    if (d >= XW) return {{(XW-1){1'b0}}, |m};
    mask = (XW'(1) << d) - XW'(1);
    return (m >> d) | {{(XW-1){1'b0}}, |(m & mask)};
  endfunction

  function automatic int lead_zeros(input logic [XW-1:0] v);
    int n;
    n = XW;
    for (int i = 0; i < XW; i++) begin
      if (v[i]) n = XW - 1 - i;
    end
    return n;
  endfunction

  logic          ys_n, eff_sub;
  logic [XW-1:0] ax, ay, diff;
  logic [XW:0]   sum;
  int            d, e, lz;

  always_comb begin
    ys_n    = ~ys;
    eff_sub = xs ^ ys_n;
    d       = int'(xe) - int'(ye);
    if (d >= 0) begin
      ax = {xm, 3'b000};
      ay = sticky_shift({ym, 3'b000}, d);
      e  = int'(xe);
    end else begin
      ax = sticky_shift({xm, 3'b000}, -d);
      ay = {ym, 3'b000};
      e  = int'(ye);
    end
    sum    = {1'b0, ax} + {1'b0, ay};
    diff   = (ax >= ay) ? (ax - ay) : (ay - ax);
    lz     = lead_zeros(diff);
    carry  = 1'b0;
    cancel = 1'b0;
    r_sign = xs;
    r_mant = sum[XW-1:0];
    if (!eff_sub) begin
      carry = sum[XW];
      if (carry) begin
        r_mant = sum[XW:1] | {{(XW-1){1'b0}}, sum[0]};
        e      = e + 1;
      end
    end else begin
      r_sign = (ax >= ay) ? xs : ys_n;
      cancel = (diff == '0);
      r_mant = XW'(diff << lz);
      if (!cancel) e = e - lz;
    end
    r_exp = EW'(e);
  end
endmodule

// File: rtl/fsub_core.sv
module fsub_core
  import fsub_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MW    = FRAC_W + 1,
  localparam int XW    = MW + 3,
  localparam int EW    = EXP_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [W-1:0]         x_in,
  input  logic [W-1:0]         y_in,
  input  logic [1:0]           rmode,
  output logic                 out_valid,
  output logic                 out_final,
  output logic                 out_invalid,
  output logic [W-1:0]         out_word,
  output logic                 out_sign,
  output logic signed [EW-1:0] out_exp,
  output logic [XW-1:0]        out_mant
);
  logic [W-1:0]         op_w  [2];
  fp_class_e            cls   [2];
  logic                 sgn   [2];
  logic signed [EW-1:0] ex_u  [2];
  logic [MW-1:0]        mt    [2];

  assign op_w[0] = x_in;
  assign op_w[1] = y_in;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fsub_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op(op_w[i]), .cls(cls[i]), .sign(sgn[i]), .exp_u(ex_u[i]), .mant(mt[i])
    );
  end

  logic                 spec_hit, spec_inv;
  logic [W-1:0]         spec_word;
  logic                 ar_cancel, ar_carry, ar_sign;
  logic signed [EW-1:0] ar_exp;
  logic [XW-1:0]        ar_mant;

  fsub_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_spec (
    .x(x_in), .y(y_in), .cx(cls[0]), .cy(cls[1]), .rmode(rmode),
    .hit(spec_hit), .word(spec_word), .invalid(spec_inv)
  );

  fsub_arith #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_arith (
    .xs(sgn[0]), .ys(sgn[1]), .xe(ex_u[0]), .ye(ex_u[1]), .xm(mt[0]), .ym(mt[1]),
    .cancel(ar_cancel), .carry(ar_carry),
    .r_sign(ar_sign), .r_exp(ar_exp), .r_mant(ar_mant)
  );

  // Named events for the checker
  logic cancel_evt, carry_evt, rounder_evt;
  assign cancel_evt  = !spec_hit && ar_cancel;
  assign carry_evt   = !spec_hit && ar_carry;
  assign rounder_evt = !spec_hit && !ar_cancel;

  logic [W-1:0] nxt_word;
  always_comb begin
    if (spec_hit)        nxt_word = spec_word;
    else if (ar_cancel)  nxt_word = {rmode == 2'b11, {(W-1){1'b0}}};
    else                 nxt_word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_final   <= 1'b0;
      out_invalid <= 1'b0;
      out_word    <= '0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_mant    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_final   <= !rounder_evt;
      out_invalid <= spec_hit && spec_inv;
      out_word    <= nxt_word;
      out_sign    <= rounder_evt ? ar_sign : 1'b0;
      out_exp     <= rounder_evt ? ar_exp  : '0;
      out_mant    <= rounder_evt ? ar_mant : '0;
    end
  end
endmodule

// File: rtl/fsub_checker.sv
module fsub_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int XW    = FRAC_W + 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  x_in,
  input logic [W-1:0]  y_in,
  input logic [1:0]    rmode,
  input logic          out_valid,
  input logic          out_final,
  input logic          out_invalid,
  input logic [W-1:0]  out_word,
  input logic [XW-1:0] out_mant,
  input logic          cancel_evt,
  input logic          carry_evt
);
  logic x_snan, y_inf, x_fin;
  assign x_snan = (&x_in[W-2:FRAC_W]) && (x_in[FRAC_W-1:0] != '0) && !x_in[FRAC_W-1];
  assign y_inf  = (&y_in[W-2:FRAC_W]) && (y_in[FRAC_W-1:0] == '0);
  assign x_fin  = !(&x_in[W-2:FRAC_W]);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_xsnan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && x_snan |=> out_final && out_invalid && out_word[FRAC_W-1]);
  assert_fin_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && x_fin && y_inf |=>
      out_word == {~$past(y_in[W-1]), {EXP_W{1'b1}}, {FRAC_W{1'b0}}});
  assert_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_final |-> out_mant[XW-1]);
  assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cancel_evt |=> out_final && !out_invalid &&
      out_word == {$past(rmode) == 2'b11, {(W-1){1'b0}}});
  assert_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && carry_evt |=> !out_final && out_mant[XW-1]);
  assert_invalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_final);
endmodule

bind fsub_core fsub_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
  .rmode(rmode), .out_valid(out_valid), .out_final(out_final),
  .out_invalid(out_invalid), .out_word(out_word), .out_mant(out_mant),
  .cancel_evt(cancel_evt), .carry_evt(carry_evt)
);

// File: tb/fsub_core_bench.sv
`timescale 1ns/1ps
module fsub_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] x_in = '0, y_in = '0;
  logic [1:0]  rmode = 2'b00;
  logic        out_valid, out_final, out_invalid, out_sign;
  logic [31:0] out_word;
  logic signed [9:0] out_exp;
  logic [26:0] out_mant;

  always #2 clk = ~clk;

  fsub_core u_fsub_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
    .rmode(rmode), .out_valid(out_valid), .out_final(out_final),
    .out_invalid(out_invalid), .out_word(out_word), .out_sign(out_sign),
    .out_exp(out_exp), .out_mant(out_mant)
  );

  typedef struct packed {
    logic        fin;
    logic        inv;
    logic [31:0] word;
    logic        sgn;
    logic [9:0]  ex;
    logic [26:0] mt;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  function automatic void unpack(input logic [31:0] v, output logic [23:0] m, output int e);
    if (v[30:23] == 0) begin
      m = {1'b0, v[22:0]}; e = -126;
      while (!m[23]) begin m = m << 1; e = e - 1; end
    end else begin
      m = {1'b1, v[22:0]}; e = int'(v[30:23]) - 127;
    end
  endfunction

  function automatic item_t model(input logic [31:0] x, input logic [31:0] y, input logic [1:0] rm);
    item_t r;
    bit xn, yn, xq, yq, xi, yi, xz, yz, xs, ys;
    logic [23:0] m1, m2;
    logic [27:0] a, b, s;
    int ex, ey;
    r = '0; r.fin = 1;
    xn = x[30:23] == 8'hFF && x[22:0] != 0; yn = y[30:23] == 8'hFF && y[22:0] != 0;
    xq = xn && x[22]; yq = yn && y[22];
    xi = x[30:23] == 8'hFF && x[22:0] == 0; yi = y[30:23] == 8'hFF && y[22:0] == 0;
    xz = x[30:0] == 0; yz = y[30:0] == 0;
    if (xn && !xq)      begin r.word = x | 32'h0040_0000; r.inv = 1; end
    else if (yn && !yq) begin r.word = y | 32'h0040_0000; r.inv = 1; end
    else if (xn) r.word = x;
    else if (yn) r.word = y;
    else if (xi && yi) begin
      if (x[31] != y[31]) r.word = x;
      else begin r.word = 32'h7FC0_0000; r.inv = 1; end
    end
    else if (yi) r.word = {~y[31], 8'hFF, 23'd0};
    else if (xi) r.word = x;
    else if (xz && yz) r.word = (x[31] != y[31]) ? x : {rm == 2'b11, 31'd0};
    else if (yz) r.word = x;
    else if (xz) r.word = y ^ 32'h8000_0000;
    else begin
      unpack(x, m1, ex); unpack(y, m2, ey);
      xs = x[31]; ys = ~y[31];
      a = {1'b0, m1, 3'b000}; b = {1'b0, m2, 3'b000};
      while (ex < ey) begin a = (a >> 1) | (a & 28'd1); ex++; end
      while (ey < ex) begin b = (b >> 1) | (b & 28'd1); ey++; end
      if (xs == ys) begin
        s = a + b; r.sgn = xs;
        if (s[27]) begin s = (s >> 1) | (s & 28'd1); ex++; end
      end else if (a >= b) begin s = a - b; r.sgn = xs; end
      else begin s = b - a; r.sgn = ys; end
      if (s == 0) r.word = {rm == 2'b11, 31'd0};
      else begin
        while (!s[26]) begin s = s << 1; ex--; end
        r.fin = 0; r.ex = 10'(ex); r.mt = s[26:0];
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [31:0] x, input logic [31:0] y, input logic [1:0] rm,
                       input item_t e, input string tag);
    @(negedge clk);
    in_valid = 1; x_in = x; y_in = y; rmode = rm;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drive_m(input logic [31:0] x, input logic [31:0] y, input logic [1:0] rm, input string tag);
    drive(x, y, rm, model(x, y, rm), tag);
  endtask

  function automatic item_t fin_item(input logic [31:0] w, input logic inv);
    item_t r; r = '0; r.fin = 1; r.inv = inv; r.word = w; return r;
  endfunction

  function automatic item_t rnd_item(input logic s, input int e, input logic [26:0] m);
    item_t r; r = '0; r.sgn = s; r.ex = 10'(e); r.mt = m; return r;
  endfunction

  // Monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      item_t e; string t; bit bad;
      checks++;
      if (exp_q.size() == 0) begin
        failures++; $display("FAIL R1 unexpected out_valid actual=1 expected=0");
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        bad = (out_final != e.fin) || (out_invalid != e.inv) ||
              (e.fin ? (out_word != e.word) :
               (out_sign != e.sgn || out_exp != e.ex || out_mant != e.mt || out_word != 0));
        if (bad) begin
          failures++;
          $display("FAIL %s actual fin=%0b inv=%0b word=%h s=%0b e=%0d m=%h expected fin=%0b inv=%0b word=%h s=%0b e=%0d m=%h",
                   t, out_final, out_invalid, out_word, out_sign, out_exp, out_mant,
                   e.fin, e.inv, e.word, e.sgn, $signed(e.ex), e.mt);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx, ry;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++; $display("FAIL R1 reset out_valid actual=%0b expected=0", out_valid);
    end
    rst_n = 1;
    // R2 signalling NaN priority
    drive(32'h7F80_0001, 32'hFF80_0005, 2'b00, fin_item(32'h7FC0_0001, 1), "R2 both snan");
    drive(32'h3F80_0000, 32'hFF80_0005, 2'b00, fin_item(32'hFFC0_0005, 1), "R2 y snan");
    drive(32'h7F80_0001, 32'hFFC0_0002, 2'b00, fin_item(32'h7FC0_0001, 1), "R2 x snan y qnan");
    // R3 quiet NaN
    drive(32'h7FC0_0001, 32'hFFC0_0002, 2'b00, fin_item(32'h7FC0_0001, 0), "R3 x qnan");
    drive(32'h3F80_0000, 32'hFFC0_0002, 2'b00, fin_item(32'hFFC0_0002, 0), "R3 y qnan");
    // R4 infinities
    drive(32'h7F80_0000, 32'h7F80_0000, 2'b00, fin_item(32'h7FC0_0000, 1), "R4 inf-inf");
    drive(32'h7F80_0000, 32'hFF80_0000, 2'b00, fin_item(32'h7F80_0000, 0), "R4 inf-(-inf)");
    // R5
    drive(32'h3F80_0000, 32'h7F80_0000, 2'b00, fin_item(32'hFF80_0000, 0), "R5 1-inf");
    drive(32'h0000_0001, 32'hFF80_0000, 2'b00, fin_item(32'h7F80_0000, 0), "R5 dn-(-inf)");
    drive(32'hFF80_0000, 32'h3F80_0000, 2'b00, fin_item(32'hFF80_0000, 0), "R5 -inf-1");
    // R6 zeros
    drive(32'h0000_0000, 32'h8000_0000, 2'b11, fin_item(32'h0000_0000, 0), "R6 0-(-0)");
    drive(32'h8000_0000, 32'h0000_0000, 2'b00, fin_item(32'h8000_0000, 0), "R6 -0-0");
    drive(32'h0000_0000, 32'h0000_0000, 2'b11, fin_item(32'h8000_0000, 0), "R6 0-0 rm11");
    drive(32'h8000_0000, 32'h8000_0000, 2'b10, fin_item(32'h0000_0000, 0), "R6 -0-(-0) rm10");
    // R7
    drive(32'h3F80_0000, 32'h8000_0000, 2'b00, fin_item(32'h3F80_0000, 0), "R7 x-0");
    drive(32'h0000_0000, 32'h3F80_0000, 2'b00, fin_item(32'hBF80_0000, 0), "R7 0-y");
    drive(32'h8000_0000, 32'h0040_0000, 2'b00, fin_item(32'h8040_0000, 0), "R7 -0-dn");
    // R8 / R12 datapath
    drive(32'h4040_0000, 32'h3F80_0000, 2'b00, rnd_item(0, 1, 27'h400_0000), "R8 3-1");
    drive(32'h3F80_0000, 32'h4040_0000, 2'b01, rnd_item(1, 1, 27'h400_0000), "R12 1-3 sign");
    drive(32'h0040_0000, 32'h0000_0001, 2'b00, rnd_item(0, -128, 27'h7FF_FFE0), "R8 dn-dn");
    // R9 sticky on long alignment
    drive(32'h3F80_0000, 32'h8000_0001, 2'b00, rnd_item(0, 0, 27'h400_0001), "R9 1+tiny");
    drive(32'h3F80_0000, 32'h0000_0001, 2'b00, rnd_item(0, -1, 27'h7FF_FFFE), "R9 1-tiny");
    // R10 exact cancel
    drive(32'h3F80_0000, 32'h3F80_0000, 2'b00, fin_item(32'h0000_0000, 0), "R10 1-1 rm00");
    drive(32'h3F80_0000, 32'h3F80_0000, 2'b11, fin_item(32'h8000_0000, 0), "R10 1-1 rm11");
    drive(32'h0000_0003, 32'h0000_0003, 2'b10, fin_item(32'h0000_0000, 0), "R10 dn cancel");
    // R11 carry
    drive(32'h3F80_0000, 32'hBF80_0000, 2'b00, rnd_item(0, 1, 27'h400_0000), "R11 1+1");
    drive(32'h3FFF_FFFF, 32'hBF80_0001, 2'b00, rnd_item(0, 1, 27'h600_0000), "R11 carry mid");
    // Random pairs against the bench model
    for (int i = 0; i < 300; i++) begin
      rx = $urandom; ry = $urandom;
      if (i % 3 == 0) ry = {ry[31], rx[30:23], ry[22:0]};
      if (i % 7 == 0) ry = {~rx[31], rx[30:0]};
      if (i % 11 == 0) rx = {rx[31], 8'h00, rx[22:0]};
      drive_m(rx, ry, 2'(i), "R8 R9 R11 R12 random");
    end
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++; $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule